// File: doc/BRIEF.md
# Memory-Block Accelerator Dispatch Scoreboard

This unit sits between a processor pipeline and a stateless compute unit that transforms one memory block into another. Each command names a function code, a source base address, a destination base address and a block size given as log2 of the byte count. The unit looks the function up in a small store of resident contexts. It allocates a scoreboard entry and hands the command to the compute unit in the same cycle it accepts it. The entry stays busy until the compute unit reports completion for that tag.

While entries are busy, every processor load and store address is compared against the blocks of the outstanding operations. Accesses that could observe or disturb an unfinished operation are held with a combinational stall. A command whose function is not resident raises a miss indication and waits until a context load places that function in one of the slots. The processor therefore sees accelerator work as if it ran in program order.

Top module: `mbx_dispatch`

## Requirements
- R1: While cmd_valid is high, ctx_miss is 1 exactly when cmd_func matches no valid resident slot. A missing command is never issued. After reset no slot is valid.
- R2: A pulse on ld_valid writes ld_func into slot ld_slot, replacing the old content, and the new function can hit from the next cycle. Function codes 14 and 15 are not loadable, and a load that carries one leaves the slot unchanged.
- R3: A command is accepted when cmd_valid is high, its context is resident, a scoreboard entry is free and no destination conflict exists. In that case cmd_ready and iss_valid are 1 in the same cycle, the command fields are passed to the iss_ outputs, and iss_tag is the lowest-numbered free entry.
- R4: A block covers 2^lsz bytes starting at the base with its low lsz bits cleared. The low lsz bits of a base are ignored.
- R5: A processor read (mem_we=0) stalls while its address lies in the destination block of any busy entry.
- R6: A processor write (mem_we=1) stalls while its address lies in the source or destination block of any busy entry. mem_stall is 0 whenever mem_valid is 0.
- R7: A command is held when its destination block overlaps the source or destination block of any busy entry. Overlap is judged by comparing both bases at the larger of the two sizes.
- R8: With all 4 entries busy, no command is accepted.
- R9: A done_valid pulse for a busy tag frees that entry from the next cycle on. In the cycle of the pulse the entry still stalls accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_func | input | 4 | Function code |
| cmd_src | input | 16 | Source block base |
| cmd_dst | input | 16 | Destination block base |
| cmd_lsz | input | 4 | log2 of block size in bytes |
| cmd_ready | output | 1 | Command accepted this cycle |
| ctx_miss | output | 1 | Command function not resident |
| ld_valid | input | 1 | Context load completes |
| ld_slot | input | 2 | Slot being loaded |
| ld_func | input | 4 | Function loaded into the slot |
| iss_valid | output | 1 | Issue to the compute unit |
| iss_tag | output | 2 | Scoreboard entry of the issued command |
| iss_func | output | 4 | Issued function code |
| iss_src | output | 16 | Issued source base |
| iss_dst | output | 16 | Issued destination base |
| iss_lsz | output | 4 | Issued size exponent |
| done_valid | input | 1 | Compute unit completion pulse |
| done_tag | input | 2 | Entry that completed |
| mem_valid | input | 1 | Processor access present |
| mem_we | input | 1 | Access is a write |
| mem_addr | input | 16 | Access byte address |
| mem_stall | output | 1 | Hold the processor access |

## Verification
The bench sweeps every byte address across and around all busy blocks, for both reads and writes. A design that checked reads against source blocks, or forgot source blocks for writes, would stall the wrong addresses at the block edges. Commands are issued with unaligned bases and with mixed sizes, so a range check that ignored the larger of two sizes would let a large destination pass over a small busy block. The bench fills the scoreboard, then releases a middle entry and expects that tag back: a design that freed entries in the same cycle as the pulse, or allocated in any other order, shows up in the stall or tag values. All 16 function codes are tried against the loaded slots, together with a refused load of a reserved code.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    // true when two addresses fall in the same 2^lsz-aligned block
    function automatic logic same_blk(input logic [31:0] a, input logic [31:0] b,
                                      input logic [4:0] lsz);
        logic [31:0] keep;
        keep = ~((32'h1 << lsz) - 32'h1);
        return (a & keep) == (b & keep);
    endfunction

    function automatic logic [4:0] max_lsz(input logic [4:0] x, input logic [4:0] y);
        return (x > y) ? x : y;
    endfunction
endpackage

// File: rtl/mbx_ctx_store.sv
module mbx_ctx_store #(
    parameter int NSLOT = 4,
    parameter int FW    = 4,
    parameter int NFUNC = 14,
    localparam int SW   = $clog2(NSLOT)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_valid,
    input  logic [SW-1:0] ld_slot,
    input  logic [FW-1:0] ld_func,
    input  logic [FW-1:0] look_func,
    output logic          hit
);
    typedef struct packed {
        logic [NSLOT-1:0]         vld;
        logic [NSLOT-1:0][FW-1:0] fn;
    } ctx_t;

    ctx_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ld_valid && (32'(ld_func) < NFUNC)) begin
            st_d.vld[ld_slot] = 1'b1;
            st_d.fn[ld_slot]  = ld_func;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        hit = 1'b0;
        for (int i = 0; i < NSLOT; i++)
            if (st_q.vld[i] && st_q.fn[i] == look_func) hit = 1'b1;
    end

    // R2
    ld_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && (32'(ld_func) < NFUNC)) |=>
        (st_q.vld[$past(ld_slot)] && st_q.fn[$past(ld_slot)] == $past(ld_func)));
    // R2
    ld_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && (32'(ld_func) >= NFUNC)) |=> $stable(st_q));
endmodule

// File: rtl/mbx_sb_table.sv
module mbx_sb_table #(
    parameter int NE = 4,
    parameter int AW = 16,
    parameter int LW = 4,
    localparam int TW = $clog2(NE)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          alloc,
    input  logic [AW-1:0] alloc_src,
    input  logic [AW-1:0] alloc_dst,
    input  logic [LW-1:0] alloc_lsz,
    input  logic          done_valid,
    input  logic [TW-1:0] done_tag,
    input  logic          mem_valid,
    input  logic          mem_we,
    input  logic [AW-1:0] mem_addr,
    output logic          mem_hit,
    output logic          dst_conf,
    output logic          full,
    output logic [TW-1:0] free_tag
);
    import mbx_pkg::*;

    typedef struct packed {
        logic [NE-1:0]         busy;
        logic [NE-1:0][AW-1:0] src;
        logic [NE-1:0][AW-1:0] dst;
        logic [NE-1:0][LW-1:0] lsz;
    } sb_t;

    sb_t sb_d, sb_q;

    // lowest free entry
    always_comb begin
        free_tag = '0;
        for (int i = NE - 1; i >= 0; i--)
            if (!sb_q.busy[i]) free_tag = TW'(i);
    end

    assign full = &sb_q.busy;

    always_comb begin
        sb_d = sb_q;
        if (done_valid) sb_d.busy[done_tag] = 1'b0;
        if (alloc) begin
            sb_d.busy[free_tag] = 1'b1;
            sb_d.src[free_tag]  = alloc_src;
            sb_d.dst[free_tag]  = alloc_dst;
            sb_d.lsz[free_tag]  = alloc_lsz;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sb_q <= '0;
        else        sb_q <= sb_d;
    end

    // range checks, one pair per entry
    logic [NE-1:0] rd_hit, wr_hit, ov_hit;
    for (genvar g = 0; g < NE; g++) begin : g_cmp
        logic [4:0] el, nl;
        assign el = 5'(sb_q.lsz[g]);
        assign nl = max_lsz(el, 5'(alloc_lsz));
        assign rd_hit[g] = sb_q.busy[g] && same_blk(32'(mem_addr), 32'(sb_q.dst[g]), el);
        assign wr_hit[g] = sb_q.busy[g] &&
            (same_blk(32'(mem_addr), 32'(sb_q.dst[g]), el) ||
             same_blk(32'(mem_addr), 32'(sb_q.src[g]), el));
        assign ov_hit[g] = sb_q.busy[g] &&
            (same_blk(32'(alloc_dst), 32'(sb_q.dst[g]), nl) ||
             same_blk(32'(alloc_dst), 32'(sb_q.src[g]), nl));
    end

    assign mem_hit  = mem_valid && (mem_we ? |wr_hit : |rd_hit);
    assign dst_conf = |ov_hit;

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !alloc);
    // R9
    done_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && sb_q.busy[done_tag]) |=> !sb_q.busy[$past(done_tag)]);
    // R3
    alloc_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alloc |=> sb_q.busy[$past(free_tag)]);
    // R3
    one_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done_valid |=> ($countones(sb_q.busy) <= $countones($past(sb_q.busy)) + 1));
endmodule

// File: rtl/mbx_dispatch.sv
module mbx_dispatch #(
    parameter int AW    = 16,
    parameter int LW    = 4,
    parameter int FW    = 4,
    parameter int NE    = 4,
    parameter int NSLOT = 4,
    parameter int NFUNC = 14,
    localparam int TW   = $clog2(NE),
    localparam int SW   = $clog2(NSLOT)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [FW-1:0] cmd_func,
    input  logic [AW-1:0] cmd_src,
    input  logic [AW-1:0] cmd_dst,
    input  logic [LW-1:0] cmd_lsz,
    output logic          cmd_ready,
    output logic          ctx_miss,
    input  logic          ld_valid,
    input  logic [SW-1:0] ld_slot,
    input  logic [FW-1:0] ld_func,
    output logic          iss_valid,
    output logic [TW-1:0] iss_tag,
    output logic [FW-1:0] iss_func,
    output logic [AW-1:0] iss_src,
    output logic [AW-1:0] iss_dst,
    output logic [LW-1:0] iss_lsz,
    input  logic          done_valid,
    input  logic [TW-1:0] done_tag,
    input  logic          mem_valid,
    input  logic          mem_we,
    input  logic [AW-1:0] mem_addr,
    output logic          mem_stall
);
    logic ctx_hit, sb_full, sb_conf;
    logic [TW-1:0] sb_free;

    mbx_ctx_store #(.NSLOT(NSLOT), .FW(FW), .NFUNC(NFUNC)) u_ctx (
        .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_slot(ld_slot),
        .ld_func(ld_func), .look_func(cmd_func), .hit(ctx_hit)
    );

    mbx_sb_table #(.NE(NE), .AW(AW), .LW(LW)) u_sb (
        .clk(clk), .rst_n(rst_n), .alloc(iss_valid), .alloc_src(cmd_src),
        .alloc_dst(cmd_dst), .alloc_lsz(cmd_lsz), .done_valid(done_valid),
        .done_tag(done_tag), .mem_valid(mem_valid), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_hit(mem_stall), .dst_conf(sb_conf),
        .full(sb_full), .free_tag(sb_free)
    );

    assign ctx_miss  = cmd_valid && !ctx_hit;
    assign cmd_ready = cmd_valid && ctx_hit && !sb_full && !sb_conf;
    assign iss_valid = cmd_ready;
    assign iss_tag   = sb_free;
    assign iss_func  = cmd_func;
    assign iss_src   = cmd_src;
    assign iss_dst   = cmd_dst;
    assign iss_lsz   = cmd_lsz;

    // R1
    miss_no_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctx_miss |-> !iss_valid);
    // R6
    idle_no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_valid |-> !mem_stall);
endmodule

// File: tb/tb_mbx_dispatch.sv
module tb_mbx_dispatch;
    logic clk = 0, rst_n = 0;
    logic cmd_valid = 0; logic [3:0] cmd_func = 0; logic [15:0] cmd_src = 0, cmd_dst = 0;
    logic [3:0] cmd_lsz = 0; logic cmd_ready, ctx_miss;
    logic ld_valid = 0; logic [1:0] ld_slot = 0; logic [3:0] ld_func = 0;
    logic iss_valid; logic [1:0] iss_tag; logic [3:0] iss_func;
    logic [15:0] iss_src, iss_dst; logic [3:0] iss_lsz;
    logic done_valid = 0; logic [1:0] done_tag = 0;
    logic mem_valid = 0, mem_we = 0; logic [15:0] mem_addr = 0; logic mem_stall;

    int checks = 0, errors = 0;
    bit m_busy [4]; int m_src [4]; int m_dst [4]; int m_lsz [4];

    always #10 clk = ~clk;

    mbx_dispatch dut (.*);

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit in_blk(int a, int base, int l);
        return (a >> l) == (base >> l);
    endfunction

    function automatic bit exp_stall(int a, bit we);
        bit s = 0;
        for (int i = 0; i < 4; i++)
            if (m_busy[i] && (in_blk(a, m_dst[i], m_lsz[i]) || (we && in_blk(a, m_src[i], m_lsz[i]))))
                s = 1;
        return s;
    endfunction

    function automatic int low_free();
        for (int i = 0; i < 4; i++) if (!m_busy[i]) return i;
        return -1;
    endfunction

    task automatic load(int slot, int f);
        ld_valid = 1; ld_slot = 2'(slot); ld_func = 4'(f);
        @(posedge clk); @(negedge clk);
        ld_valid = 0;
    endtask

    // drive a command, check acceptance; record the model on accept
    task automatic issue(string req, int f, int s, int d, int l, bit exp_ok);
        int t;
        cmd_valid = 1; cmd_func = 4'(f); cmd_src = 16'(s); cmd_dst = 16'(d); cmd_lsz = 4'(l);
        #1;
        check(req, int'(cmd_ready), int'(exp_ok));
        check(req, int'(iss_valid), int'(exp_ok));
        if (exp_ok) begin
            t = low_free();
            check(req, int'(iss_tag), t);
            check(req, int'(iss_dst), d);
            check(req, int'(iss_src), s);
            m_busy[t] = 1; m_src[t] = s; m_dst[t] = d; m_lsz[t] = l;
        end
        @(posedge clk); @(negedge clk);
        cmd_valid = 0;
    endtask

    task automatic sweep(string req, int lo, int hi);
        mem_valid = 1;
        for (int a = lo; a <= hi; a++) begin
            for (int w = 0; w < 2; w++) begin
                mem_addr = 16'(a); mem_we = w[0];
                #1;
                check(req, int'(mem_stall), int'(exp_stall(a, w[0])));
            end
        end
        mem_valid = 0;
    endtask

    initial begin
        #4000000;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) m_busy[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset: nothing resident
        cmd_valid = 1; cmd_func = 1; cmd_dst = 16'h800; mem_valid = 1; mem_addr = 0; mem_we = 1;
        #1;
        check("R1 reset miss", int'(ctx_miss), 1);
        check("R1 reset ready", int'(cmd_ready), 0);
        check("R6 reset stall", int'(mem_stall), 0);
        cmd_valid = 0; mem_valid = 0;
        for (int s = 0; s < 4; s++) load(s, s + 1);
        // R1 sweep every function code
        for (int f = 0; f < 16; f++) begin
            cmd_valid = 1; cmd_func = 4'(f); cmd_dst = 16'h800; cmd_lsz = 0;
            #1;
            check("R1 miss", int'(ctx_miss), (f >= 1 && f <= 4) ? 0 : 1);
            check("R1 ready", int'(cmd_ready), (f >= 1 && f <= 4) ? 1 : 0);
        end
        cmd_valid = 0;
        // R2 reserved code is not loaded
        load(0, 14);
        cmd_valid = 1; cmd_func = 1; #1;
        check("R2 reserved keeps slot", int'(ctx_miss), 0);
        cmd_func = 14; #1;
        check("R2 reserved not resident", int'(ctx_miss), 1);
        cmd_valid = 0;
        // R3 first issue
        issue("R3 issue A", 1, 'h100, 'h200, 4, 1);
        // R7 conflicts
        issue("R7 dst inside busy dst", 2, 'h000, 'h208, 2, 0);
        issue("R7 large dst over busy src", 2, 'h000, 'h100, 8, 0);
        issue("R7 disjoint large dst", 2, 'h200, 'h180, 7, 1);
        // R4 unaligned bases
        issue("R4 unaligned issue", 3, 'h205, 'h405, 4, 1);
        issue("R3 fourth", 4, 'h600, 'h700, 0, 1);
        // R8 full
        issue("R8 full blocks", 4, 'h000, 'h900, 0, 0);
        cmd_valid = 1; cmd_func = 4; #1;
        check("R8 full not a miss", int'(ctx_miss), 0);
        cmd_valid = 0;
        // R4 R5 R6 exhaustive address sweep
        sweep("R5/R6 sweep", 'h0E0, 'h71F);
        mem_valid = 0; mem_we = 0; mem_addr = 16'h205; #1;
        check("R6 no access no stall", int'(mem_stall), 0);
        // R9 release entry 1
        done_valid = 1; done_tag = 1; mem_valid = 1; mem_we = 0; mem_addr = 16'h190; #1;
        check("R9 still busy in pulse cycle", int'(mem_stall), 1);
        @(posedge clk); @(negedge clk);
        done_valid = 0; m_busy[1] = 0; #1;
        check("R9 freed next cycle", int'(mem_stall), 0);
        mem_valid = 0;
        issue("R9 reuse freed tag", 4, 'h000, 'h900, 0, 1);
        check("R9 reused tag", int'(m_busy[1]), 1);
        sweep("R5/R6 sweep after reuse", 'h0E0, 'h91F);
        // R2 reload replaces slot
        load(2, 9);
        cmd_valid = 1; cmd_func = 3; #1;
        check("R2 replaced func misses", int'(ctx_miss), 1);
        cmd_func = 9; #1;
        check("R2 new func hits", int'(ctx_miss), 0);
        cmd_valid = 0;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule